// File: doc/BRIEF.md
# Static-Memory Bus Turnaround Sequencer

This block takes single-beat transfer requests from an internal valid/ready port and plays them out on an asynchronous static-memory bus. The bus has four active-low chip selects, a 24-bit address, 8-bit data, and active-low read and write strobes. Each transfer holds its strobe for a fixed two-cycle phase. Between consecutive transfers the block decides whether the bus needs a turnaround cycle. If the chip select changes, it inserts one idle cycle with every control line high. If a read follows a write on the same device, it inserts one early-read wait cycle. It never inserts both kinds at once.

The request port follows a valid/ready handshake. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high while the bus is idle and in the last strobe cycle of the current transfer, so a queued request can follow with no dead cycle. It is low in every other strobe cycle and in every inserted cycle. During a low `req_ready` the requester must hold `req_valid` and the request fields steady. Read data returns on `rsp_valid`, a one-cycle pulse that has no back-pressure.

The write data bus is split into an output value, an output enable and an input value, so the pad ring can build the bidirectional pin.

Top module: `xbus_gapseq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four chip selects and both strobes are high, `bus_doe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: The first transfer after reset gets no inserted cycle: its strobe phase starts in the cycle right after acceptance.
- R3: A transfer holds chip select `bus_cs_n[k]` low for exactly 2 cycles, where k is the accepted `req_cs` (0..3). The address is driven on `bus_addr` during those cycles. `bus_rd_n` is low for a read (`req_write`=0) and `bus_wr_n` is low for a write (`req_write`=1). At most one chip select is low at any time.
- R4: `bus_doe` is high exactly while `bus_wr_n` is low, and `bus_dout` then carries the accepted write data.
- R5: Read data is sampled from `bus_din` in the last strobe cycle. It is presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the cycle after the strobe phase ends.
- R6: When a transfer targets a different chip select from the one before it, exactly one idle cycle precedes its strobe phase. In that cycle every chip select and both strobes are high.
- R7: When a read follows a write on the same chip select, exactly one early-read wait cycle, with all controls high, precedes the read strobe.
- R8: A write followed by a read on a different chip select gets only the single idle cycle of R6, never two.
- R9: Read after read, write after write and write after read on the same chip select get no inserted cycle.
- R10: `req_ready` is high when the bus is idle and in the last strobe cycle, and low in other strobe cycles and in inserted cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 24 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| req_cs | input | 2 | Target chip select index |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Returned read data |
| bus_addr | output | 24 | Memory address |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | 8 | Data driven toward memory |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 8 | Data returned from memory |

## Verification
The hardest case to reach from the ports is a request that is accepted in the last strobe cycle of the previous transfer. Only there does the insertion decision compare two live transfers with no idle cycle between them. The bench sweeps all 64 ordered pairs of chip select and direction. It keeps the second request valid while the first is still strobing, so every pair reaches that overlap. It then counts the all-high cycles between the two strobe phases and compares the count with the value given by the rules for chip-select change and write-to-read turnaround. The first transfer of each pair also follows the second of the pair before it, so history carried across pairs is covered too.

// File: rtl/xbus_gapseq_pkg.sv
package xbus_gapseq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CSGAP, PH_EARLY, PH_STROBE} phase_t;
  typedef enum logic [1:0] {GAP_NONE, GAP_CS, GAP_EARLY} gap_t;
endpackage

// File: rtl/xbus_gap_decide.sv
module xbus_gap_decide
  import xbus_gapseq_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic            hist_vld,
  input  logic [CS_W-1:0] hist_cs,
  input  logic            hist_wr,
  input  logic [CS_W-1:0] nxt_cs,
  input  logic            nxt_wr,
  output gap_t            gap
);
  // A device change wins over the write-to-read rule, so the two never stack.
  always_comb begin
    gap = GAP_NONE;
    if (hist_vld) begin
      if (hist_cs != nxt_cs)       gap = GAP_CS;
      else if (hist_wr && !nxt_wr) gap = GAP_EARLY;
    end
  end
endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive #(
  parameter int NCS    = 4,
  parameter int CS_W   = 2,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              strobe,
  input  logic [CS_W-1:0]   cs,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [NCS-1:0]    bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe
);
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign bus_cs_n[g] = !(strobe && (cs == CS_W'(g)));
  end

  assign bus_rd_n = !(strobe && !wr);
  assign bus_wr_n = !(strobe && wr);
  assign bus_doe  = strobe && wr;
  assign bus_dout = bus_doe ? wdata : '0;
  assign bus_addr = addr_in;
endmodule

// File: rtl/xbus_rd_capture.sv
module xbus_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= din;
    end
  end
endmodule

// File: rtl/xbus_gapseq.sv
module xbus_gapseq
  import xbus_gapseq_pkg::*;
#(
  parameter int NCS        = 4,
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [$clog2(NCS)-1:0]   req_cs,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [NCS-1:0]           bus_cs_n,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  output logic [DATA_W-1:0]        bus_dout,
  output logic                     bus_doe,
  input  logic [DATA_W-1:0]        bus_din
);
  localparam int CS_W  = $clog2(NCS);
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STROBE_CYC - 1);

  phase_t             phase, phase_d;
  logic [CNT_W-1:0]   cnt, cnt_d;
  logic [ADDR_W-1:0]  cur_addr;
  logic [DATA_W-1:0]  cur_wdata;
  logic [CS_W-1:0]    cur_cs;
  logic               cur_wr;
  logic               hist_vld;
  logic               last_beat, accept, strobing;
  gap_t               gap;

  assign strobing  = (phase == PH_STROBE);
  assign last_beat = strobing && (cnt == LAST_CNT);
  assign req_ready = (phase == PH_IDLE) || last_beat;
  assign accept    = req_valid && req_ready;

  // Latched request doubles as the history of the last access.
  xbus_gap_decide #(.CS_W(CS_W)) u_decide (
    .hist_vld (hist_vld),
    .hist_cs  (cur_cs),
    .hist_wr  (cur_wr),
    .nxt_cs   (req_cs),
    .nxt_wr   (req_write),
    .gap      (gap)
  );

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt;
    unique case (phase)
      PH_CSGAP, PH_EARLY: begin
        phase_d = PH_STROBE;
        cnt_d   = '0;
      end
      PH_STROBE: begin
        if (!last_beat) cnt_d = cnt + CNT_W'(1);
        else            phase_d = PH_IDLE;
      end
      default: ;
    endcase
    if (accept) begin
      cnt_d = '0;
      unique case (gap)
        GAP_CS:    phase_d = PH_CSGAP;
        GAP_EARLY: phase_d = PH_EARLY;
        default:   phase_d = PH_STROBE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_cs    <= '0;
      cur_wr    <= 1'b0;
      hist_vld  <= 1'b0;
    end else begin
      phase <= phase_d;
      cnt   <= cnt_d;
      if (accept) begin
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
        cur_cs    <= req_cs;
        cur_wr    <= req_write;
        hist_vld  <= 1'b1;
      end
    end
  end

  xbus_pin_drive #(
    .NCS(NCS), .CS_W(CS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_pins (
    .strobe   (strobing),
    .cs       (cur_cs),
    .wr       (cur_wr),
    .addr_in  (cur_addr),
    .wdata    (cur_wdata),
    .bus_addr (bus_addr),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_dout (bus_dout),
    .bus_doe  (bus_doe)
  );

  xbus_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (last_beat && !cur_wr),
    .din       (bus_din),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/xbus_gapseq_chk.sv
module xbus_gapseq_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] bus_cs_n,
  input logic           bus_rd_n,
  input logic           bus_wr_n,
  input logic           bus_doe,
  input logic           rsp_valid
);
  // R3
  cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R3
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) == (bus_cs_n != '1));

  // R6
  no_direct_cs_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(bus_cs_n) != '1) && (bus_cs_n != '1)) |-> (bus_cs_n == $past(bus_cs_n)));

  // R7
  early_read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> $past(bus_wr_n));

  // R4
  doe_matches_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe == !bus_wr_n);

  // R5
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind xbus_gapseq xbus_gapseq_chk #(.NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs_n  (bus_cs_n),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_doe   (bus_doe),
  .rsp_valid (rsp_valid)
);

// File: tb/xbus_gapseq_test.sv
`timescale 1ns/1ps
module xbus_gapseq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_addr;
  logic        req_write;
  logic [7:0]  req_wdata;
  logic [1:0]  req_cs;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [23:0] bus_addr;
  logic [3:0]  bus_cs_n;
  logic        bus_rd_n, bus_wr_n, bus_doe;
  logic [7:0]  bus_dout, bus_din;

  always #2.5 clk = ~clk;

  xbus_gapseq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata), .req_cs(req_cs),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din)
  );

  // Memory model: read data derived from the address.
  assign bus_din = !bus_rd_n ? (bus_addr[7:0] ^ 8'hA5) : 8'h00;

  int vec = 0;
  int bad = 0;
  bit hv = 1'b0;
  int hcs = 0;
  bit hwr = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ctl();
    return {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe};
  endfunction

  function automatic int exp_gap(input bit v, input int pcs, input bit pwr, input int ncs, input bit nwr);
    if (!v) return 0;
    if (pcs != ncs) return 1;
    if (pwr && !nwr) return 1;
    return 0;
  endfunction

  function automatic string gap_tag(input bit v, input int pcs, input bit pwr, input int ncs, input bit nwr);
    if (!v) return "R2";
    if (pcs != ncs) return (pwr && !nwr) ? "R8" : "R6";
    if (pwr && !nwr) return "R7";
    return "R9";
  endfunction

  task automatic idle_cyc(input string tag);
    chk(ctl() == 7'b1111110 && !req_ready, {tag, " inserted cycle (R10 ready low)"},
        {24'd0, req_ready, ctl()}, {24'd0, 1'b0, 7'b1111110});
  endtask

  task automatic strobe_cyc(input int cs, input bit wr, input logic [23:0] a,
                            input logic [7:0] wd, input int beat, input string tag);
    logic [6:0] e;
    e = {~(4'b0001 << cs), wr, !wr, wr};
    chk(ctl() == e, {tag, " R3 strobe controls"}, {25'd0, ctl()}, {25'd0, e});
    chk(bus_addr == a, "R3 address", {8'd0, bus_addr}, {8'd0, a});
    chk(req_ready == (beat == 1), "R10 ready in strobe", {31'd0, req_ready}, {31'd0, beat == 1});
    if (wr) chk(bus_dout == wd, "R4 write data", {24'd0, bus_dout}, {24'd0, wd});
  endtask

  task automatic drive(input int cs, input bit wr, input logic [23:0] a, input logic [7:0] wd);
    req_valid = 1'b1;
    req_cs    = 2'(cs);
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
  endtask

  task automatic run_pair(input int ca, input bit wa, input int cb, input bit wb, input int k);
    logic [23:0] aa, ab;
    logic [7:0]  da, db;
    int ga, gb;
    string ta, tb;
    aa = (24'(ca) << 20) | 24'(k * 2);
    ab = (24'(cb) << 20) | 24'(k * 2 + 1);
    da = 8'(k * 3 + 1);
    db = 8'(k * 5 + 7);
    @(negedge clk);
    chk(req_ready, "R10 ready when idle", {31'd0, req_ready}, 32'd1);
    drive(ca, wa, aa, da);
    @(posedge clk);
    ga = exp_gap(hv, hcs, hwr, ca, wa);
    ta = gap_tag(hv, hcs, hwr, ca, wa);
    hv = 1'b1; hcs = ca; hwr = wa;
    @(negedge clk);
    drive(cb, wb, ab, db);
    for (int i = 0; i < ga; i++) begin
      idle_cyc(ta);
      @(negedge clk);
    end
    strobe_cyc(ca, wa, aa, da, 0, ta);
    @(negedge clk);
    strobe_cyc(ca, wa, aa, da, 1, ta);
    @(posedge clk);
    gb = exp_gap(1'b1, ca, wa, cb, wb);
    tb = gap_tag(1'b1, ca, wa, cb, wb);
    hcs = cb; hwr = wb;
    @(negedge clk);
    req_valid = 1'b0;
    if (!wa)
      chk(rsp_valid && rsp_rdata == (aa[7:0] ^ 8'hA5), "R5 read return",
          {23'd0, rsp_valid, rsp_rdata}, {23'd0, 1'b1, aa[7:0] ^ 8'hA5});
    else
      chk(!rsp_valid, "R5 no return after write", {31'd0, rsp_valid}, 32'd0);
    for (int i = 0; i < gb; i++) begin
      idle_cyc(tb);
      @(negedge clk);
      chk(!rsp_valid, "R5 single pulse", {31'd0, rsp_valid}, 32'd0);
    end
    strobe_cyc(cb, wb, ab, db, 0, tb);
    @(negedge clk);
    strobe_cyc(cb, wb, ab, db, 1, tb);
    @(negedge clk);
    if (!wb)
      chk(rsp_valid && rsp_rdata == (ab[7:0] ^ 8'hA5), "R5 read return",
          {23'd0, rsp_valid, rsp_rdata}, {23'd0, 1'b1, ab[7:0] ^ 8'hA5});
    else
      chk(!rsp_valid, "R5 no return after write", {31'd0, rsp_valid}, 32'd0);
    chk(ctl() == 7'b1111110, "R10 bus idle after pair", {25'd0, ctl()}, {25'd0, 7'b1111110});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    vec++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_cs = '0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    repeat (4) @(negedge clk);
    chk(ctl() == 7'b1111110 && !rsp_valid && req_ready, "R1 reset state",
        {23'd0, req_ready, rsp_valid, ctl()}, {23'd0, 1'b1, 1'b0, 7'b1111110});
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl() == 7'b1111110 && !rsp_valid && req_ready, "R1 after reset",
        {23'd0, req_ready, rsp_valid, ctl()}, {23'd0, 1'b1, 1'b0, 7'b1111110});
    for (int ca = 0; ca < 4; ca++)
      for (int wa = 0; wa < 2; wa++)
        for (int cb = 0; cb < 4; cb++)
          for (int wb = 0; wb < 2; wb++)
            run_pair(ca, wa[0], cb, wb[0], ca * 16 + wa * 8 + cb * 2 + wb);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule